// File: doc/BRIEF.md
# Register Bank with Program Counter Port

This block is the architectural register storage of a small RISC datapath. It holds sixteen 32-bit registers, numbered r0 to r15. Two read ports are purely combinational, so both operands of one instruction (the A-bus and B-bus values) are available in the same cycle. A single synchronous write port takes the ALU result and stores it at the next rising clock edge.

Register r15 is the program counter. It has its own load port, its own output, and a private +4 incrementer. Fetch can therefore advance the PC on every cycle without using the ALU and without taking a general port. The PC can be loaded in three ways, in fixed priority order:
- the dedicated PC load port, highest priority;
- the general write port addressed to r15;
- the incrementer, lowest priority.

Reset clears only the PC. r0 to r14 have no reset and must be written before they are read.

Top module: `reg_bank_pc`

## Requirements
- R1: While `rst` is high at a rising edge, the PC (r15) becomes 0 at that edge. Both `pc_out` and a read of address 15 then return 0.
- R2: The two read ports are independent and combinational. In the same cycle, `rd_a_data` shows the register selected by `rd_a_addr` and `rd_b_data` shows the register selected by `rd_b_addr`, for any pair of addresses 0..15.
- R3: With `wr_en` high at a rising edge, register `wr_addr` takes `wr_data` at that edge.
- R4: With `pc_inc` high, `pc_wr_en` low, and no general write to address 15, the PC becomes its old value plus 4 (modulo 2^32) at the edge.
- R5: A general write to address 15 with `pc_wr_en` low loads `wr_data` into the PC and overrides `pc_inc`.
- R6: With `pc_wr_en` high, the PC loads `pc_wr_data`, regardless of `pc_inc` and of any general write to address 15.
- R7: A register read in the same cycle that it is written returns the old value until the edge; after the edge the new value is visible.
- R8: With `wr_en` low, no register r0..r14 changes. With no PC load and `pc_inc` low, the PC holds its value.
- R9: A general write to r0..r14 and a PC update in the same cycle both take effect.
- R10: A read of address 15 on either port returns the same value as `pc_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the PC |
| rd_a_addr | input | 4 | Register select for the A read port |
| rd_a_data | output | 32 | A-bus operand |
| rd_b_addr | input | 4 | Register select for the B read port |
| rd_b_data | output | 32 | B-bus operand |
| wr_en | input | 1 | General write enable |
| wr_addr | input | 4 | General write register select |
| wr_data | input | 32 | ALU result to store |
| pc_wr_en | input | 1 | Dedicated PC load enable |
| pc_wr_data | input | 32 | Dedicated PC load value |
| pc_inc | input | 1 | Advance the PC by 4 |
| pc_out | output | 32 | Current PC value |

## Verification
The PC incrementer and a PC load can fall in the same cycle. The load comes from the general write port, the dedicated port, or both. A general write to another register can also coincide with a PC update.

The bench sweeps all sixteen combinations of increment, dedicated load, general write enable, and general target (r15 or r5). Each combination uses distinct data values, so the winning source can be read directly from `pc_out`. Expected PC values follow from the priority order, dedicated load over general write over increment. The r5 contents are checked in the same cycle to confirm that the general write landed alongside the PC update.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

    localparam int unsigned DATA_W   = 32;
    localparam int unsigned NUM_REGS = 16;
    localparam int unsigned IDX_W    = $clog2(NUM_REGS);
    localparam int unsigned PC_IDX   = NUM_REGS - 1;
    localparam int unsigned NUM_GPR  = NUM_REGS - 1;
    localparam int unsigned PC_STEP  = 4;
    localparam int unsigned NUM_RD   = 2;

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [IDX_W-1:0]  idx_t;

    // One write request into the bank.
    typedef struct packed {
        logic  en;
        idx_t  idx;
        word_t data;
    } wr_req_t;

    // Source that updates the program counter this cycle.
    typedef enum logic [1:0] {
        PC_KEEP     = 2'd0,
        PC_ADVANCE  = 2'd1,
        PC_LOAD_GEN = 2'd2,
        PC_LOAD_DED = 2'd3
    } pc_src_e;

    function automatic word_t pc_advance(word_t cur);
        return cur + word_t'(PC_STEP);
    endfunction

    function automatic logic targets_pc(wr_req_t r);
        return r.en && (r.idx == idx_t'(PC_IDX));
    endfunction

    function automatic logic targets_gpr(wr_req_t r, int unsigned k);
        return r.en && (r.idx == idx_t'(k));
    endfunction

endpackage

// File: rtl/rb_pc_unit.sv
module rb_pc_unit
    import regbank_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  wr_req_t gen_req,
    input  logic    ded_en,
    input  word_t   ded_data,
    input  logic    inc,
    output word_t   pc_q,
    output pc_src_e pc_src
);

    word_t pc_next;

    // Priority: dedicated load, then general write to r15, then increment.
    always_comb begin
        if (ded_en) begin
            pc_src = PC_LOAD_DED;
        end else if (targets_pc(gen_req)) begin
            pc_src = PC_LOAD_GEN;
        end else if (inc) begin
            pc_src = PC_ADVANCE;
        end else begin
            pc_src = PC_KEEP;
        end
    end

    always_comb begin
        unique case (pc_src)
            PC_LOAD_DED: pc_next = ded_data;
            PC_LOAD_GEN: pc_next = gen_req.data;
            PC_ADVANCE:  pc_next = pc_advance(pc_q);
            default:     pc_next = pc_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= '0;
        end else begin
            pc_q <= pc_next;
        end
    end

endmodule

// File: rtl/rb_gpr_array.sv
module rb_gpr_array
    import regbank_pkg::*;
(
    input  logic                          clk,
    input  wr_req_t                       wr_req,
    output logic [NUM_GPR-1:0][DATA_W-1:0] gpr_q
);

    // r0..r14 carry no reset; only the addressed register loads.
    for (genvar g = 0; g < NUM_GPR; g++) begin : g_reg
        word_t cell_q;
        logic  hit;

        assign hit = targets_gpr(wr_req, g);

        always_ff @(posedge clk) begin
            if (hit) begin
                cell_q <= wr_req.data;
            end
        end

        assign gpr_q[g] = cell_q;
    end

endmodule

// File: rtl/rb_read_port.sv
module rb_read_port
    import regbank_pkg::*;
(
    input  idx_t                          sel,
    input  logic [NUM_GPR-1:0][DATA_W-1:0] gpr_q,
    input  word_t                         pc_q,
    output word_t                         data
);

    always_comb begin
        data = pc_q;
        for (int unsigned i = 0; i < NUM_GPR; i++) begin
            if (sel == idx_t'(i)) begin
                data = gpr_q[i];
            end
        end
    end

endmodule

// File: rtl/reg_bank_pc.sv
module reg_bank_pc
    import regbank_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [3:0]  rd_a_addr,
    output logic [31:0] rd_a_data,
    input  logic [3:0]  rd_b_addr,
    output logic [31:0] rd_b_data,
    input  logic        wr_en,
    input  logic [3:0]  wr_addr,
    input  logic [31:0] wr_data,
    input  logic        pc_wr_en,
    input  logic [31:0] pc_wr_data,
    input  logic        pc_inc,
    output logic [31:0] pc_out
);

    wr_req_t                        gen_req;
    word_t                          pc_q;
    pc_src_e                        pc_src;
    logic [NUM_GPR-1:0][DATA_W-1:0] gpr_q;
    idx_t                           rd_sel [NUM_RD];
    word_t                          rd_val [NUM_RD];

    assign gen_req = '{en: wr_en, idx: wr_addr, data: wr_data};

    rb_pc_unit i_pc (
        .clk      (clk),
        .rst      (rst),
        .gen_req  (gen_req),
        .ded_en   (pc_wr_en),
        .ded_data (pc_wr_data),
        .inc      (pc_inc),
        .pc_q     (pc_q),
        .pc_src   (pc_src)
    );

    rb_gpr_array i_gpr (
        .clk    (clk),
        .wr_req (gen_req),
        .gpr_q  (gpr_q)
    );

    assign rd_sel[0] = rd_a_addr;
    assign rd_sel[1] = rd_b_addr;

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        rb_read_port i_port (
            .sel   (rd_sel[p]),
            .gpr_q (gpr_q),
            .pc_q  (pc_q),
            .data  (rd_val[p])
        );
    end

    assign rd_a_data = rd_val[0];
    assign rd_b_data = rd_val[1];
    assign pc_out    = pc_q;

endmodule

// File: rtl/rb_checker.sv
module rb_checker (
    input logic        clk,
    input logic        rst,
    input logic [3:0]  rd_a_addr,
    input logic [31:0] rd_a_data,
    input logic [3:0]  rd_b_addr,
    input logic [31:0] rd_b_data,
    input logic        wr_en,
    input logic [3:0]  wr_addr,
    input logic [31:0] wr_data,
    input logic        pc_wr_en,
    input logic [31:0] pc_wr_data,
    input logic        pc_inc,
    input logic [31:0] pc_out
);

    logic gen_pc;
    assign gen_pc = wr_en && (wr_addr == 4'd15);

    AST_RESET_PC: assert property (@(posedge clk) rst |=> pc_out == 32'd0); // R1

    AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
        (pc_inc && !pc_wr_en && !gen_pc) |=> pc_out == $past(pc_out) + 32'd4); // R4

    AST_GEN_PC_LOAD: assert property (@(posedge clk) disable iff (rst)
        (gen_pc && !pc_wr_en) |=> pc_out == $past(wr_data)); // R5

    AST_DED_PC_LOAD: assert property (@(posedge clk) disable iff (rst)
        pc_wr_en |=> pc_out == $past(pc_wr_data)); // R6

    AST_PC_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!pc_inc && !pc_wr_en && !gen_pc) |=> $stable(pc_out)); // R8

    AST_PORT_A_PC: assert property (@(posedge clk) disable iff (rst)
        (rd_a_addr == 4'd15) |-> rd_a_data == pc_out); // R10

    AST_PORT_B_PC: assert property (@(posedge clk) disable iff (rst)
        (rd_b_addr == 4'd15) |-> rd_b_data == pc_out); // R10

endmodule

bind reg_bank_pc rb_checker i_rb_checker (.*);

// File: tb/test_reg_bank_pc.sv
module test_reg_bank_pc;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  rd_a_addr, rd_b_addr, wr_addr;
    logic [31:0] rd_a_data, rd_b_data, wr_data, pc_wr_data, pc_out;
    logic        wr_en, pc_wr_en, pc_inc;

    int checks   = 0;
    int failures = 0;
    logic [31:0] model [16];
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    reg_bank_pc i_reg_bank_pc (
        .clk(clk), .rst(rst),
        .rd_a_addr(rd_a_addr), .rd_a_data(rd_a_data),
        .rd_b_addr(rd_b_addr), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .pc_wr_en(pc_wr_en), .pc_wr_data(pc_wr_data),
        .pc_inc(pc_inc), .pc_out(pc_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] pat(input int i);
        return (32'h0101_0101 * (i + 1)) ^ 32'hC3C3_0000;
    endfunction

    // Drive one cycle, update the model by the priority rules, check after the edge.
    task automatic cycle(input logic inc, input logic ded, input logic [31:0] dd,
                         input logic gen, input logic [3:0] ga, input logic [31:0] gd);
        @(negedge clk);
        pc_inc = inc; pc_wr_en = ded; pc_wr_data = dd;
        wr_en = gen; wr_addr = ga; wr_data = gd;
        if (ded)                     model[15] = dd;
        else if (gen && ga == 4'd15) model[15] = gd;
        else if (inc)                model[15] = model[15] + 32'd4;
        if (gen && ga != 4'd15)      model[ga] = gd;
        @(posedge clk);
        #1;
        pc_inc = 1'b0; pc_wr_en = 1'b0; wr_en = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; pc_inc = 1'b1; pc_wr_en = 1'b0; wr_en = 1'b0;
        wr_addr = '0; wr_data = '0; pc_wr_data = '0;
        rd_a_addr = 4'd15; rd_b_addr = 4'd15;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 pc_out at reset", pc_out, 32'd0);
        chk("R1 r15 via port A at reset", rd_a_data, 32'd0);
        @(negedge clk);
        rst = 1'b0; pc_inc = 1'b0;
        model[15] = 32'd0;

        // R3: fill r0..r14, read back each one after its write edge
        for (int i = 0; i < 15; i++) begin
            cycle(1'b0, 1'b0, 32'd0, 1'b1, 4'(i), pat(i));
            rd_a_addr = 4'(i);
            #1;
            chk($sformatf("R3 write r%0d", i), rd_a_data, pat(i));
            chk("R8 pc held during fill", pc_out, 32'd0);
        end

        // R2 / R10: every address pair on both ports
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                rd_a_addr = 4'(a); rd_b_addr = 4'(b);
                #1;
                chk($sformatf("R2 port A r%0d", a), rd_a_data, model[a]);
                chk($sformatf("R2 port B r%0d", b), rd_b_data, model[b]);
            end
        end
        rd_a_addr = 4'd15; #1;
        chk("R10 port A equals pc_out", rd_a_data, pc_out);

        // R4 R5 R6 R8 R9: all combinations of PC sources plus a general write
        rd_b_addr = 4'd5;
        for (int c = 0; c < 16; c++) begin
            cycle(c[0], c[1], 32'h0000_8000 + 32'(c * 16),
                  c[2], c[3] ? 4'd15 : 4'd5, 32'h0000_1000 + 32'(c * 16));
            #1;
            chk($sformatf("R4 R5 R6 R8 pc combo %0d", c), pc_out, model[15]);
            chk($sformatf("R9 r5 combo %0d", c), rd_b_data, model[5]);
        end

        // R4: wrap of the incrementer
        cycle(1'b0, 1'b1, 32'hFFFF_FFFC, 1'b0, 4'd0, 32'd0);
        chk("R6 load near top", pc_out, 32'hFFFF_FFFC);
        cycle(1'b1, 1'b0, 32'd0, 1'b0, 4'd0, 32'd0);
        chk("R4 wrap to zero", pc_out, 32'd0);
        cycle(1'b1, 1'b0, 32'd0, 1'b0, 4'd0, 32'd0);
        chk("R4 step after wrap", pc_out, 32'd4);

        // R7: read-during-write on a GPR and on the PC
        @(negedge clk);
        rd_a_addr = 4'd7; rd_b_addr = 4'd15;
        wr_en = 1'b1; wr_addr = 4'd7; wr_data = 32'hDEAD_BEEF; pc_inc = 1'b1;
        #1;
        chk("R7 r7 old before edge", rd_a_data, model[7]);
        chk("R7 r15 old before edge", rd_b_data, model[15]);
        model[7] = 32'hDEAD_BEEF; model[15] = model[15] + 32'd4;
        @(posedge clk); #1;
        wr_en = 1'b0; pc_inc = 1'b0;
        chk("R7 r7 new after edge", rd_a_data, model[7]);
        chk("R7 r15 new after edge", rd_b_data, model[15]);

        // R8: data and address driven but enable low
        @(negedge clk);
        wr_en = 1'b0; wr_addr = 4'd9; wr_data = 32'h1234_5678;
        @(posedge clk); #1;
        for (int i = 0; i < 16; i++) begin
            rd_a_addr = 4'(i); #1;
            chk($sformatf("R8 no write r%0d", i), rd_a_data, model[i]);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule